// File: doc/BRIEF.md
# Single-Cycle Barrel Shift Unit with Funnel Shift

This block is the shift unit of a 32-bit integer pipeline. Each accepted operation is completed in one clock cycle and the result is registered. Four operations are supported: a left shift, a logical right shift, an arithmetic right shift and a funnel shift. For the first three, the shift amount is taken from the first operand, which may be a register value or an immediate supplied by decode. The value that is shifted is the second operand.

The funnel shift joins the two operands into a 64-bit word, with the first operand in the upper half. It shifts that word right and returns the low 32 bits. Its shift amount is not taken from its own operands. It comes from a small internal count field, and only the logical right shift writes that field. A program therefore issues a logical right shift to set up the count and then issues funnel shifts that use it. A rotate is obtained by giving the same value in both halves.

None of these operations asks for a condition-code update. A left shift by zero is therefore a register move that leaves the flags unchanged.

Top module: `shift_unit`

## Requirements
- R1: Operation codes on `opCode` are 2'b00 left shift, 2'b01 logical right shift, 2'b10 arithmetic right shift and 2'b11 funnel shift. A left shift returns `opB` shifted left by `opA[4:0]` with zeros filled in at the bottom.
- R2: A logical right shift returns `opB` shifted right by `opA[4:0]` with zeros filled in at the top.
- R3: An arithmetic right shift returns `opB` shifted right by `opA[4:0]`, filling the top with copies of `opB[31]`.
- R4: A funnel shift returns bits [c+31:c] of {`opA`,`opB`}, where c is the stored count. When `opA` equals `opB`, the result is `opB` rotated right by c.
- R5: The stored count is zero after reset. It is loaded with `opA[4:0]` only when a logical right shift is accepted. Left shifts, arithmetic shifts, funnel shifts and cycles with `opValid` low leave it unchanged, even when `opCode` shows a logical right shift.
- R6: Only the low 5 bits of `opA` set the shift amount. For example, a count of 37 shifts by 5.
- R7: `ccUpdate` is low with every result. A left shift by zero returns `opB` unchanged.
- R8: `resValid` and `result` are updated one clock edge after `opValid` is sampled high. `resValid` is low in the cycle after `opValid` was low. During reset, `resValid` and `result` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Operation is accepted this cycle |
| opCode | input | 2 | Operation select (see R1) |
| opA | input | 32 | Shift count operand; upper funnel word |
| opB | input | 32 | Value shifted; lower funnel word |
| result | output | 32 | Registered shift result |
| resValid | output | 1 | Result produced by the previous accepted operation |
| ccUpdate | output | 1 | Request to update the condition code (never raised by shifts) |

## Verification
The assertions check several things on every cycle: the one-cycle result latency, the fill bit at the vacated end for left, logical right and arithmetic right shifts, the identity result of a zero-count move, and the absence of any condition-code request. They also check that the stored count loads only on an accepted logical right shift and holds otherwise. The full result values can only be shown by the bench's scenarios. These include funnel shifts whose count was set several operations earlier, rotates, counts with the upper bits set, and a logical right shift presented with `opValid` low that must not disturb the count used by a later funnel shift.

// File: rtl/shift_unit_pkg.sv
package shift_unit_pkg;

  typedef enum logic [1:0] {
    OP_SHL  = 2'b00,
    OP_SHR  = 2'b01,
    OP_SRA  = 2'b10,
    OP_SHRD = 2'b11
  } shiftOp_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;     // register a new result
    logic loadCnt;     // write the stored count field
    logic funnelMode;  // use stored count and opA as upper word
    logic arithFill;   // upper word is sign copies of opB
    logic leftDir;     // bit-reverse around the right funnel
  } shiftStrb_t;

endpackage

// File: rtl/shift_funnel.sv
module shift_funnel #(
  parameter int DATA_W = 32,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] hiWord,
  input  logic [DATA_W-1:0] loWord,
  input  logic [CNT_W-1:0]  amt,
  output logic [DATA_W-1:0] outWord
);

  localparam int PAIR_W = 2 * DATA_W;

  logic [PAIR_W-1:0] stage [CNT_W+1];

  assign stage[0] = {hiWord, loWord};

  // One log stage per count bit
  for (genvar s = 0; s < CNT_W; s++) begin : g_stage
    assign stage[s+1] = amt[s] ? (stage[s] >> (1 << s)) : stage[s];
  end

  assign outWord = stage[CNT_W][DATA_W-1:0];

endmodule

// File: rtl/shift_ctrl.sv
module shift_ctrl
  import shift_unit_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       opValid,
  input  logic [1:0] opCode,
  output shiftStrb_t strb,
  output logic       resValid,
  output logic       ccUpdate
);

  shiftOp_e opSel;

  always_comb begin
    opSel           = shiftOp_e'(opCode);
    strb            = '0;
    strb.capture    = opValid;
    strb.loadCnt    = opValid && (opSel == OP_SHR);
    strb.funnelMode = (opSel == OP_SHRD);
    strb.arithFill  = (opSel == OP_SRA);
    strb.leftDir    = (opSel == OP_SHL);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resValid <= 1'b0;
      ccUpdate <= 1'b0;
    end else begin
      resValid <= opValid;
      ccUpdate <= 1'b0;  // shifts never touch the flags
    end
  end

endmodule

// File: rtl/shift_dp.sv
module shift_dp
  import shift_unit_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  shiftStrb_t        strb,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] result,
  output logic [CNT_W-1:0]  storedCnt
);

  logic [CNT_W-1:0]  amt;
  logic [DATA_W-1:0] revB;
  logic [DATA_W-1:0] loSel;
  logic [DATA_W-1:0] hiSel;
  logic [DATA_W-1:0] funnelOut;
  logic [DATA_W-1:0] revOut;
  logic [DATA_W-1:0] shaped;

  for (genvar i = 0; i < DATA_W; i++) begin : g_rev
    assign revB[i]   = opB[DATA_W-1-i];
    assign revOut[i] = funnelOut[DATA_W-1-i];
  end

  always_comb begin
    amt   = strb.funnelMode ? storedCnt : opA[CNT_W-1:0];
    loSel = strb.leftDir ? revB : opB;
    if (strb.funnelMode)
      hiSel = opA;
    else if (strb.arithFill)
      hiSel = {DATA_W{opB[DATA_W-1]}};
    else
      hiSel = '0;
    shaped = strb.leftDir ? revOut : funnelOut;
  end

  shift_funnel #(.DATA_W(DATA_W)) u_funnel (
    .hiWord (hiSel),
    .loWord (loSel),
    .amt    (amt),
    .outWord(funnelOut)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      result    <= '0;
      storedCnt <= '0;
    end else begin
      if (strb.capture) result <= shaped;
      if (strb.loadCnt) storedCnt <= opA[CNT_W-1:0];
    end
  end

endmodule

// File: rtl/shift_unit.sv
module shift_unit
  import shift_unit_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [1:0]        opCode,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] result,
  output logic              resValid,
  output logic              ccUpdate
);

  shiftStrb_t       strb;
  logic [CNT_W-1:0] storedCnt;

  shift_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .opValid (opValid),
    .opCode  (opCode),
    .strb    (strb),
    .resValid(resValid),
    .ccUpdate(ccUpdate)
  );

  shift_dp #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .opA      (opA),
    .opB      (opB),
    .result   (result),
    .storedCnt(storedCnt)
  );

endmodule

// File: rtl/shift_unit_chk.sv
module shift_unit_chk #(
  parameter int DATA_W = 32,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input logic              clk,
  input logic              rstN,
  input logic              opValid,
  input logic [1:0]        opCode,
  input logic [DATA_W-1:0] opA,
  input logic [DATA_W-1:0] opB,
  input logic [DATA_W-1:0] result,
  input logic              resValid,
  input logic              ccUpdate,
  input logic [CNT_W-1:0]  storedCnt
);

  logic hasAmt;
  assign hasAmt = (opA[CNT_W-1:0] != '0);

  p_latency_r8: assert property (@(posedge clk) disable iff (!rstN)
    opValid |=> resValid);

  p_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> !resValid);

  p_no_cc_r7: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> !ccUpdate);

  p_move_r7: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == 2'b00 && !hasAmt) |=> (result == $past(opB)));

  p_shl_fill_r1: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == 2'b00 && hasAmt) |=> !result[0]);

  p_shr_fill_r2: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == 2'b01 && hasAmt) |=> !result[DATA_W-1]);

  p_sra_sign_r3: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == 2'b10) |=> (result[DATA_W-1] == $past(opB[DATA_W-1])));

  p_cnt_load_r5: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == 2'b01) |=> (storedCnt == $past(opA[CNT_W-1:0])));

  p_cnt_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(opValid && opCode == 2'b01) |=> $stable(storedCnt));

endmodule

bind shift_unit shift_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .opValid  (opValid),
  .opCode   (opCode),
  .opA      (opA),
  .opB      (opB),
  .result   (result),
  .resValid (resValid),
  .ccUpdate (ccUpdate),
  .storedCnt(storedCnt)
);

// File: tb/sim_shift_unit.sv
`timescale 1ns/1ps
module sim_shift_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [1:0]  opCode = 2'b00;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic [31:0] result;
  logic        resValid;
  logic        ccUpdate;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sbq[$];
  logic [4:0] modelCnt = '0;

  always #5 clk = ~clk;

  shift_unit u0 (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .opA(opA), .opB(opB), .result(result), .resValid(resValid),
    .ccUpdate(ccUpdate)
  );

  function automatic logic [31:0] model(input logic [1:0] op,
                                        input logic [31:0] a,
                                        input logic [31:0] b,
                                        input logic [4:0] st);
    logic [63:0] pair;
    case (op)
      2'b00: model = b << a[4:0];
      2'b01: model = b >> a[4:0];
      2'b10: model = $unsigned($signed(b) >>> a[4:0]);
      default: begin
        pair  = {a, b} >> st;
        model = pair[31:0];
      end
    endcase
  endfunction

  task automatic doOp(input logic [1:0] op, input logic [31:0] a,
                      input logic [31:0] b, input string tag);
    item_t it;
    @(negedge clk);
    opValid = 1'b1; opCode = op; opA = a; opB = b;
    it.exp = model(op, a, b, modelCnt);
    it.tag = tag;
    sbq.push_back(it);
    if (op == 2'b01) modelCnt = a[4:0];
  endtask

  task automatic idle(input logic [1:0] op, input logic [31:0] a);
    @(negedge clk);
    opValid = 1'b0; opCode = op; opA = a; opB = 32'hFFFF_FFFF;
  endtask

  // Monitor: pops expected results as they appear
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rstN && resValid) begin
        checks++;
        if (sbq.size() == 0) begin
          errors++;
          $display("FAIL R8 unexpected resValid result=%h expected no result", result);
        end else begin
          item_t it;
          it = sbq.pop_front();
          if (result !== it.exp) begin
            errors++;
            $display("FAIL %s result=%h expected %h", it.tag, result, it.exp);
          end
          checks++;
          if (ccUpdate !== 1'b0) begin
            errors++;
            $display("FAIL R7 ccUpdate=%b expected 0 (%s)", ccUpdate, it.tag);
          end
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    checks++;
    if (resValid !== 1'b0 || result !== 32'h0) begin
      errors++;
      $display("FAIL R8 reset resValid=%b result=%h expected 0 00000000", resValid, result);
    end
    @(negedge clk);
    rstN = 1'b1;

    doOp(2'b11, 32'hDEAD_BEEF, 32'h1234_5678, "R5 funnel with reset count");
    doOp(2'b00, 32'd4,  32'h8000_00F1, "R1 shl 4");
    doOp(2'b00, 32'd31, 32'h0000_0003, "R1 shl 31");
    doOp(2'b00, 32'd0,  32'hA5A5_1234, "R7 move by shl 0");
    doOp(2'b01, 32'd12, 32'hF0F0_F0F0, "R2 shr 12");
    doOp(2'b10, 32'd8,  32'h8123_4567, "R3 sra negative");
    doOp(2'b10, 32'd31, 32'h7FFF_FFFF, "R3 sra positive 31");
    doOp(2'b10, 32'd31, 32'h8000_0000, "R3 sra negative 31");
    doOp(2'b00, 32'd37, 32'h0000_0001, "R6 shl count 37");
    doOp(2'b01, 32'hFFFF_FFE8, 32'h8000_0000, "R6 shr count upper bits");
    doOp(2'b11, 32'h0000_00AB, 32'h1122_3344, "R4 funnel count 8");
    doOp(2'b01, 32'd13, 32'h0000_FFFF, "R2 shr loads 13");
    doOp(2'b11, 32'hCAFE_F00D, 32'hCAFE_F00D, "R4 rotate by 13");
    doOp(2'b00, 32'd3, 32'h1, "R5 shl keeps count");
    doOp(2'b10, 32'd2, 32'h4, "R5 sra keeps count");
    doOp(2'b11, 32'h0, 32'h8000_0000, "R5 funnel after other ops");
    idle(2'b01, 32'd1);
    idle(2'b01, 32'd2);
    doOp(2'b11, 32'h0000_0001, 32'h0000_0000, "R5 idle shr ignored");
    doOp(2'b01, 32'd0, 32'h89AB_CDEF, "R2 shr 0 loads 0");
    doOp(2'b11, 32'hFFFF_FFFF, 32'h5555_0000, "R4 funnel count 0");
    doOp(2'b01, 32'd31, 32'hFFFF_FFFF, "R2 shr 31");
    doOp(2'b11, 32'h1357_9BDF, 32'h0246_8ACE, "R4 funnel count 31");
    idle(2'b00, 32'd0);
    repeat (4) @(negedge clk);
    checks++;
    if (sbq.size() != 0) begin
      errors++;
      $display("FAIL R8 results missing count=%0d expected 0", sbq.size());
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R8 watchdog expired actual hung expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule